// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block paces periodic auto-refresh for a single-data-rate SDRAM controller. A 3-bit interval code chooses how often refresh is owed: two codes give intervals of roughly 15.6 µs and 7.8 µs when the memory clock runs at 133 MHz, one code gives a fast 128-clock interval, and every other code switches periodic refresh off. The off state covers the self-refresh case. Each time the chosen interval runs out, the block raises a one-cycle tick.

Every tick adds one to a count of refreshes still owed. The command scheduler grants refreshes through an acknowledge input, and each grant takes one off the count. A level request output stays high while anything is owed. Refresh pacing starts only after the controller signals that power-up initialization is complete. The block does not issue the refresh command, precharge banks, or signal self-refresh entry or exit. It only times the intervals and keeps the count of refreshes owed.

Top module: `rfsh_timer`

## Requirements
- R1: After reset, `refTick` and `refReq` are 0 and `pendCount` is 0.
- R2: With `initDone` high and `refMode` = 7, take the first rising edge at which both are seen as edge 0. `refTick` then goes high after edges 128, 256 and so on (parameter `FAST_CYC`).
- R3: With `refMode` = 2, the interval is 1037 clocks (parameter `SHORT_CYC`, 7.8 µs at 133 MHz), counted the same way as in R2.
- R4: With `refMode` = 1, the interval is 2075 clocks (parameter `LONG_CYC`, 15.6 µs at 133 MHz), counted the same way as in R2.
- R5: `refMode` values 0, 3, 4, 5 and 6 produce no ticks.
- R6: While `initDone` is low, no ticks are produced, whatever the value of `refMode`.
- R7: Any change of `refMode` restarts the interval. Take the first rising edge at which the new code is seen as edge 0: the next tick follows after exactly one full interval of the new code, and no count left over from the old code can cause an earlier tick.
- R8: Each tick adds one to `pendCount`, which saturates at `PEND_MAX` (default 8). `refReq` is 1 exactly when `pendCount` is nonzero.
- R9: An edge with `refAck` high and no tick lowers a nonzero `pendCount` by one. `refAck` is ignored when `pendCount` is 0.
- R10: An edge that carries both a tick and `refAck` leaves a nonzero `pendCount` unchanged, including when it is saturated.
- R11: When the code is switched to an off code, refreshes already owed stay in `pendCount`.
- R12: `refTick` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| initDone | input | 1 | Power-up initialization finished; enables pacing |
| refMode | input | 3 | Interval code: 1 long, 2 short, 7 fast, others off |
| refAck | input | 1 | Scheduler granted one owed refresh |
| refTick | output | 1 | One-cycle pulse when an interval expires |
| refReq | output | 1 | High while any refresh is owed |
| pendCount | output | 4 | Number of refreshes owed, saturating |

## Verification
The checker assumes that `refAck` is a one-cycle grant that never stands for more than one refresh per edge. It also assumes that `refMode` and `initDone` are ordinary synchronous levels, so the code seen at an edge is the code the scheduler meant.

The stimulus changes every input on the falling edge and samples outputs there too. Grants are given only while a refresh is owed, except in the single case that checks a grant is ignored when nothing is owed. Code changes are placed in the middle of an interval, so that the restart rule is actually exercised.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  localparam logic [2:0] CODE_LONG  = 3'd1;
  localparam logic [2:0] CODE_SHORT = 3'd2;
  localparam logic [2:0] CODE_FAST  = 3'd7;

  // strobes from control to the interval counter
  typedef struct packed {
    logic load;  // reload interval for the current code
    logic dec;   // count one clock down
  } rfshStrb_t;

  function automatic logic codeRuns(input logic [2:0] code);
    return (code == CODE_LONG) || (code == CODE_SHORT) || (code == CODE_FAST);
  endfunction

endpackage

// File: rtl/rfsh_dpath.sv
module rfsh_dpath
  import rfsh_pkg::*;
#(
  parameter int LONG_CYC  = 2075,
  parameter int SHORT_CYC = 1037,
  parameter int FAST_CYC  = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] refMode,
  input  rfshStrb_t  strb,
  output logic       cntZero
);

  localparam int MAX_AB  = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int MAX_CYC = (MAX_AB > FAST_CYC) ? MAX_AB : FAST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC);

  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cnt;

  // interval minus one, so a zero count marks the last clock of the interval
  always_comb begin
    case (refMode)
      CODE_LONG:  reloadVal = CNT_W'(LONG_CYC - 1);
      CODE_SHORT: reloadVal = CNT_W'(SHORT_CYC - 1);
      CODE_FAST:  reloadVal = CNT_W'(FAST_CYC - 1);
      default:    reloadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.load) begin
      cnt <= reloadVal;
    end else if (strb.dec) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntZero = (cnt == '0);

endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
#(
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initDone,
  input  logic [2:0]        refMode,
  input  logic              refAck,
  input  logic              cntZero,
  output rfshStrb_t         strb,
  output logic              refTick,
  output logic [PEND_W-1:0] pendCount
);

  logic [2:0]        modePrev;
  logic              armed;
  logic              active;
  logic              running;
  logic              expire;
  logic [PEND_W-1:0] pendNext;

  assign active  = initDone && codeRuns(refMode);
  // counting only continues when the same code was active on the prior edge
  assign running = active && armed && (refMode == modePrev);
  assign expire  = running && cntZero;

  always_comb begin
    strb.load = !running || cntZero;
    strb.dec  = running && !cntZero;
  end

  always_comb begin
    pendNext = pendCount;
    if (expire && refAck && (pendCount != '0)) begin
      pendNext = pendCount;
    end else if (expire) begin
      if (pendCount != PEND_W'(PEND_MAX)) pendNext = pendCount + PEND_W'(1);
    end else if (refAck && (pendCount != '0)) begin
      pendNext = pendCount - PEND_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePrev  <= '0;
      armed     <= 1'b0;
      refTick   <= 1'b0;
      pendCount <= '0;
    end else begin
      modePrev  <= refMode;
      armed     <= active;
      refTick   <= expire;
      pendCount <= pendNext;
    end
  end

endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer
  import rfsh_pkg::*;
#(
  parameter int LONG_CYC  = 2075,
  parameter int SHORT_CYC = 1037,
  parameter int FAST_CYC  = 128,
  parameter int PEND_MAX  = 8,
  localparam int PEND_W   = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initDone,
  input  logic [2:0]        refMode,
  input  logic              refAck,
  output logic              refTick,
  output logic              refReq,
  output logic [PEND_W-1:0] pendCount
);

  rfshStrb_t strb;
  logic      cntZero;

  rfsh_ctrl #(
    .PEND_MAX (PEND_MAX),
    .PEND_W   (PEND_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .initDone  (initDone),
    .refMode   (refMode),
    .refAck    (refAck),
    .cntZero   (cntZero),
    .strb      (strb),
    .refTick   (refTick),
    .pendCount (pendCount)
  );

  rfsh_dpath #(
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC),
    .FAST_CYC  (FAST_CYC)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .refMode (refMode),
    .strb    (strb),
    .cntZero (cntZero)
  );

  assign refReq = (pendCount != '0);

endmodule

// File: rtl/rfsh_timer_chk.sv
module rfsh_timer_chk #(
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = $clog2(PEND_MAX + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              initDone,
  input logic [2:0]        refMode,
  input logic              refAck,
  input logic              refTick,
  input logic [PEND_W-1:0] pendCount
);

  always_comb begin
    if (rstN) AST_PEND_BOUND: assert (int'(pendCount) <= PEND_MAX); // R8
  end

  AST_TICK_ONECYC: assert property (@(posedge clk) disable iff (!rstN)
    refTick |=> !refTick); // R12

  AST_TICK_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rstN)
    refTick |-> $past(initDone)); // R6

  AST_TICK_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    refTick |-> ($past(refMode) == 3'd1 || $past(refMode) == 3'd2 || $past(refMode) == 3'd7)); // R5

  AST_PEND_INC: assert property (@(posedge clk) disable iff (!rstN)
    (refTick && !$past(refAck) && int'($past(pendCount)) < PEND_MAX)
      |-> (pendCount == $past(pendCount) + 1'b1)); // R8

  AST_PEND_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (!refTick && $past(refAck) && $past(pendCount) != '0)
      |-> (pendCount == $past(pendCount) - 1'b1)); // R9

  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!refTick && $past(pendCount) == '0) |-> (pendCount == '0)); // R9

  AST_TICK_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (refTick && $past(refAck) && $past(pendCount) != '0)
      |-> (pendCount == $past(pendCount))); // R10

endmodule

bind rfsh_timer rfsh_timer_chk #(.PEND_MAX(PEND_MAX)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .initDone  (initDone),
  .refMode   (refMode),
  .refAck    (refAck),
  .refTick   (refTick),
  .pendCount (pendCount)
);

// File: tb/rfsh_timer_bench.sv
module rfsh_timer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       initDone = 1'b0;
  logic [2:0] refMode = 3'd0;
  logic       refAck = 1'b0;
  logic       refTick;
  logic       refReq;
  logic [3:0] pendCount;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rfsh_timer u_rfsh_timer (
    .clk       (clk),
    .rstN      (rstN),
    .initDone  (initDone),
    .refMode   (refMode),
    .refAck    (refAck),
    .refTick   (refTick),
    .refReq    (refReq),
    .pendCount (pendCount)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stepWatch(input int n, output int ticks);
    ticks = 0;
    repeat (n) begin
      @(negedge clk);
      if (refTick) ticks++;
    end
  endtask

  task automatic tReset();
    step(3);
    rstN = 1'b1;
    step(1);
    chk(refTick == 1'b0, "R1 tick", int'(refTick), 0);
    chk(refReq == 1'b0, "R1 req", int'(refReq), 0);
    chk(pendCount == 4'd0, "R1 pend", int'(pendCount), 0);
  endtask

  task automatic tInitGate();
    int k;
    refMode = 3'd7;
    stepWatch(300, k);
    chk(k == 0, "R6 ticks before init", k, 0);
    chk(pendCount == 4'd0, "R6 pend", int'(pendCount), 0);
  endtask

  task automatic tFast();
    int k;
    initDone = 1'b1;
    stepWatch(128, k);
    chk(k == 0 && pendCount == 0, "R2 early tick", k, 0);
    step(1);
    chk(refTick == 1'b1, "R2 first tick", int'(refTick), 1);
    chk(pendCount == 4'd1, "R8 pend after tick", int'(pendCount), 1);
    chk(refReq == 1'b1, "R8 req level", int'(refReq), 1);
    step(1);
    chk(refTick == 1'b0, "R12 tick width", int'(refTick), 0);
    stepWatch(126, k);
    chk(k == 0, "R2 gap", k, 0);
    step(1);
    chk(refTick == 1'b1 && pendCount == 4'd2, "R2 second tick", int'(pendCount), 2);
    refMode = 3'd0;
    stepWatch(300, k);
    chk(k == 0, "R5 code 0 ticks", k, 0);
    chk(pendCount == 4'd2, "R11 owed kept", int'(pendCount), 2);
  endtask

  task automatic tAck();
    refAck = 1'b1;
    step(1);
    chk(pendCount == 4'd1, "R9 dec", int'(pendCount), 1);
    step(1);
    chk(pendCount == 4'd0 && refReq == 1'b0, "R9 dec to zero", int'(pendCount), 0);
    step(1);
    chk(pendCount == 4'd0, "R9 ack at zero ignored", int'(pendCount), 0);
    refAck = 1'b0;
  endtask

  task automatic tSaturate();
    int k;
    refMode = 3'd7;
    stepWatch(1280, k);
    chk(k == 9, "R2 tick count", k, 9);
    chk(pendCount == 4'd8, "R8 saturate", int'(pendCount), 8);
    refAck = 1'b1;
    step(1);
    chk(refTick == 1'b1 && pendCount == 4'd8, "R10 tick with ack", int'(pendCount), 8);
    step(1);
    chk(pendCount == 4'd7, "R9 dec from full", int'(pendCount), 7);
    refMode = 3'd0;
    step(7);
    refAck = 1'b0;
    chk(pendCount == 4'd0, "R9 drained", int'(pendCount), 0);
  endtask

  task automatic tReserved();
    int k;
    for (int c = 3; c <= 6; c++) begin
      refMode = 3'(c);
      stepWatch(200, k);
      chk(k == 0 && pendCount == 0, $sformatf("R5 code %0d", c), k, 0);
    end
  endtask

  task automatic tShortLong();
    int k;
    refMode = 3'd2;
    stepWatch(1037, k);
    chk(k == 0, "R3 early tick", k, 0);
    step(1);
    chk(refTick == 1'b1 && pendCount == 4'd1, "R3 tick at 1037", int'(pendCount), 1);
    stepWatch(500, k);
    refMode = 3'd1;
    stepWatch(2075, k);
    chk(k == 0 && pendCount == 4'd1, "R7 no stale tick", k, 0);
    step(1);
    chk(refTick == 1'b1 && pendCount == 4'd2, "R4 tick at 2075", int'(pendCount), 2);
    refMode = 3'd0;
    refAck = 1'b1;
    step(2);
    refAck = 1'b0;
  endtask

  task automatic tInitDrop();
    int k;
    refMode = 3'd7;
    initDone = 1'b0;
    stepWatch(300, k);
    chk(k == 0 && pendCount == 0, "R6 init low", k, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tReset();
    tInitGate();
    tFast();
    tAck();
    tSaturate();
    tReserved();
    tShortLong();
    tInitDrop();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule